// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This engine fetches a board's configuration image from a small three-wire serial EEPROM without software help. After reset it starts on its own, and a later run can be started with a one-cycle `start` pulse. The engine drives select, clock and command data towards the memory and samples the memory's data return. Each access is one word read. The command frame has a fixed length, and 16 clocked data bits follow it.

A run begins with a probe. The probe reads word 0 with a narrow (6-bit) address. An all-ones answer means the fitted part needs 8 address bits, and every later read uses 8 bits. The engine then reads words 0 through 63 in order and keeps a 16-bit wrap-around sum. The image is accepted only when that sum comes to the fixed magic value 0xBABA. The first three words also yield a 48-bit station address, which is presented only for an accepted image and is zero otherwise. When a run ends, `done` pulses for one cycle, `busy` falls, and the results stay in place until the next run completes.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Every access opens with a 13-bit command frame, sent MSB first on `rom_mosi`. The frame is leading zeros, then the start bit 1, then the read opcode bits 1 and 0, then the word address (6 or 8 bits). The memory's clock rises exactly 13 times during the frame.
- R2: After the frame, 16 more clock periods bring in the data word MSB first. Each bit is sampled from `rom_miso` at the end of the clock-high phase, before the clock falls.
- R3: `rom_mosi` never changes while `rom_clk` is high. Each clock half period lasts max(HALF_CYC, CLK_MHZ) system clocks.
- R4: `rom_cs` is high for the whole frame and data phase of one word and low between words. `rom_clk` is never high while `rom_cs` is low.
- R5: The probe reads address 0 with 6 address bits. A result of 0xFFFF makes every following read of the run use 8 address bits. Any other result keeps 6 bits.
- R6: After the probe, words 0x00 to 0x3F are read in ascending order, so a run makes 65 accesses.
- R7: `image_ok` is 1 exactly when the 16-bit wrap-around sum of the 64 words read equals 0xBABA.
- R8: For an accepted image, `station_addr` byte k occupies bits 8k+7:8k. Bytes 0 to 5 are the low byte of word 0, the high byte of word 0, then the same for word 1 and word 2, so `station_addr` = {word2, word1, word0}.
- R9: For a rejected image, `station_addr` is all zeros.
- R10: In reset, all outputs are low. A run starts by itself after reset and on a `start` pulse while idle.
- R11: A `start` pulse while `busy` is high has no effect: no extra accesses and no extra `done`.
- R12: `done` is high for exactly one cycle per run, in the first cycle where `busy` is low. `station_addr` and `image_ok` change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request pulse, honoured only while idle |
| rom_cs | output | 1 | Memory select, high during one word access |
| rom_clk | output | 1 | Memory shift clock |
| rom_mosi | output | 1 | Command bits towards the memory |
| rom_miso | input | 1 | Data bits from the memory |
| station_addr | output | 48 | Station address, {word2, word1, word0} or zero |
| image_ok | output | 1 | Checksum of the last run matched 0xBABA |
| done | output | 1 | One-cycle end-of-run pulse |
| busy | output | 1 | A run is in progress |

## Verification
The loader is run against a memory model that can act as a 6-bit or an 8-bit part. The model decodes every frame it receives and answers all-ones when the frame's address width does not match its own. Good images on both part sizes show that the probe choice, the read order and the byte unpacking are right. Images with one flipped bit separate a correct sum comparison from one that passes everything. A 6-bit part whose word 0 is 0xFFFF drives the probe into a wrong choice, and the run must then reject the image. Each access is also checked for clock half-period width, data stability while the clock is high and select framing, and the bench also checks that `start` is ignored while busy and that the results are held after a run.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  localparam int FRAME_LEN  = 13;
  localparam int DATA_LEN   = 16;
  localparam int ADDR_NARROW = 6;
  localparam int ADDR_WIDE   = 8;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_SEL,
    SH_LOW,
    SH_HIGH,
    SH_DESEL
  } shift_st_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROBE_GO,
    SQ_PROBE_WAIT,
    SQ_SCAN_GO,
    SQ_SCAN_WAIT
  } seq_st_t;

  // Read frame: zero padding, start bit, opcode "10", then the address.
  function automatic logic [FRAME_LEN-1:0] read_frame(input logic [7:0] addr,
                                                       input logic       wide);
    logic [FRAME_LEN-1:0] f;
    if (wide) f = {2'b00, 3'b110, addr};
    else      f = {4'b0000, 3'b110, addr[5:0]};
    return f;
  endfunction

  // Wrap-around checksum step.
  function automatic logic [15:0] sum_step(input logic [15:0] acc,
                                           input logic [15:0] w);
    return acc + w;
  endfunction

  // Byte k of the station address sits at bits 8k+7:8k.
  function automatic logic [47:0] pack_station(input logic [15:0] w0,
                                               input logic [15:0] w1,
                                               input logic [15:0] w2);
    return {w2, w1, w0};
  endfunction

endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
  parameter int HALF_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int HC = (HALF_CYC < 1) ? 1 : HALF_CYC;
  localparam int CW = (HC > 1) ? $clog2(HC) : 1;
  localparam logic [CW-1:0] TOP = CW'(HC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || cnt_q == TOP)  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == TOP);

  // The phase counter advances by one each cycle inside a phase.
  assert_tick_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tick_o)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/eecfg_shifter.sv
module eecfg_shifter
  import eecfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic [7:0]  addr_i,
  input  logic        wide_i,
  input  logic        tick_i,
  input  logic        sdi_i,
  output logic        run_o,
  output logic        cs_o,
  output logic        sk_o,
  output logic        sdo_o,
  output logic [15:0] word_o,
  output logic        word_valid_o
);

  localparam int LAST_BIT = FRAME_LEN + DATA_LEN - 1;
  localparam int CNT_W    = $clog2(FRAME_LEN + DATA_LEN);

  shift_st_t            st_q, st_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [FRAME_LEN-1:0] frm_q, frm_n;
  logic [15:0]          shr_q, shr_n;
  logic                 fin;
  logic                 cs_q, sk_q, sdo_q, wv_q;
  logic                 cs_n, sk_n, sdo_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    frm_n = frm_q;
    shr_n = shr_q;
    fin   = 1'b0;
    unique case (st_q)
      SH_IDLE: if (go_i) begin
        st_n  = SH_SEL;
        frm_n = read_frame(addr_i, wide_i);
        cnt_n = '0;
      end
      SH_SEL:  if (tick_i) st_n = SH_LOW;
      SH_LOW:  if (tick_i) st_n = SH_HIGH;
      SH_HIGH: if (tick_i) begin
        if (int'(cnt_q) >= FRAME_LEN) shr_n = {shr_q[14:0], sdi_i};
        if (int'(cnt_q) == LAST_BIT) st_n = SH_DESEL;
        else begin
          cnt_n = cnt_q + 1'b1;
          st_n  = SH_LOW;
        end
      end
      SH_DESEL: if (tick_i) begin
        st_n = SH_IDLE;
        fin  = 1'b1;
      end
      default: st_n = SH_IDLE;
    endcase
  end

  // Pin values for the next state, registered so the pins never glitch.
  always_comb begin
    cs_n  = (st_n == SH_SEL) || (st_n == SH_LOW) || (st_n == SH_HIGH);
    sk_n  = (st_n == SH_HIGH);
    sdo_n = 1'b0;
    if (((st_n == SH_LOW) || (st_n == SH_HIGH)) && (int'(cnt_n) < FRAME_LEN))
      sdo_n = frm_n[FRAME_LEN - 1 - int'(cnt_n)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      frm_q <= '0;
      shr_q <= '0;
      cs_q  <= 1'b0;
      sk_q  <= 1'b0;
      sdo_q <= 1'b0;
      wv_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      frm_q <= frm_n;
      shr_q <= shr_n;
      cs_q  <= cs_n;
      sk_q  <= sk_n;
      sdo_q <= sdo_n;
      wv_q  <= fin;
    end
  end

  assign run_o        = (st_q != SH_IDLE);
  assign cs_o         = cs_q;
  assign sk_o         = sk_q;
  assign sdo_o        = sdo_q;
  assign word_o       = shr_q;
  assign word_valid_o = wv_q;

  assert_clk_needs_select_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_q |-> cs_q);

  assert_data_steady_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_q && $past(sk_q)) |-> $stable(sdo_q));

  assert_clk_moves_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sk_q) |-> $past(tick_i));

  assert_select_dropped_per_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wv_q |-> !cs_q);

  assert_go_only_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !run_o);

endmodule

// File: rtl/eecfg_seq.sv
module eecfg_seq
  import eecfg_pkg::*;
#(
  parameter int          WORDS = 64,
  parameter logic [15:0] MAGIC = 16'hBABA
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        word_valid_i,
  input  logic [15:0] word_i,
  output logic        go_o,
  output logic [7:0]  addr_o,
  output logic        wide_o,
  output logic [47:0] station_o,
  output logic        ok_o,
  output logic        done_o,
  output logic        busy_o
);

  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  seq_st_t       st_q;
  logic          boot_q;
  logic          wide_q;
  logic [IW-1:0] idx_q;
  logic [15:0]   sum_q;
  logic [15:0]   w_q [3];
  logic [47:0]   station_q;
  logic          ok_q, done_q;

  logic          kick;
  logic          last_word;
  logic [15:0]   sum_final;
  logic          image_good;

  assign kick       = (st_q == SQ_IDLE) && (start_i || boot_q);
  assign last_word  = (st_q == SQ_SCAN_WAIT) && word_valid_i && (idx_q == LAST_IDX);
  assign sum_final  = sum_step(sum_q, word_i);
  assign image_good = (sum_final == MAGIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      boot_q    <= 1'b1;
      wide_q    <= 1'b0;
      idx_q     <= '0;
      sum_q     <= '0;
      w_q[0]    <= '0;
      w_q[1]    <= '0;
      w_q[2]    <= '0;
      station_q <= '0;
      ok_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (kick) begin
          boot_q <= 1'b0;
          st_q   <= SQ_PROBE_GO;
        end
        SQ_PROBE_GO: st_q <= SQ_PROBE_WAIT;
        SQ_PROBE_WAIT: if (word_valid_i) begin
          wide_q <= (word_i == 16'hFFFF);
          idx_q  <= '0;
          sum_q  <= '0;
          st_q   <= SQ_SCAN_GO;
        end
        SQ_SCAN_GO: st_q <= SQ_SCAN_WAIT;
        SQ_SCAN_WAIT: if (word_valid_i) begin
          sum_q <= sum_final;
          if (int'(idx_q) < 3) w_q[idx_q[1:0]] <= word_i;
          if (last_word) begin
            ok_q      <= image_good;
            station_q <= image_good ? pack_station(w_q[0], w_q[1], w_q[2]) : '0;
            done_q    <= 1'b1;
            st_q      <= SQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SQ_SCAN_GO;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign go_o      = (st_q == SQ_PROBE_GO) || (st_q == SQ_SCAN_GO);
  assign addr_o    = (st_q == SQ_PROBE_GO) ? 8'd0 : 8'(idx_q);
  assign wide_o    = (st_q == SQ_PROBE_GO) ? 1'b0 : wide_q;
  assign station_o = station_q;
  assign ok_o      = ok_q;
  assign done_o    = done_q;
  assign busy_o    = (st_q != SQ_IDLE);

  assert_done_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_when_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);

  assert_results_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> ($stable(station_q) && $stable(ok_q)));

  assert_zero_on_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !ok_q) |-> (station_q == '0));

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !last_word) |=> busy_o);

  assert_scan_ascending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == SQ_SCAN_WAIT) && word_valid_i && !last_word) |=> (idx_q == $past(idx_q) + 1'b1));

  assert_probe_narrow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_PROBE_GO) |-> (!wide_o && addr_o == 8'd0));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int          HALF_CYC = 100,
  parameter int          CLK_MHZ  = 100,
  parameter int          WORDS    = 64,
  parameter logic [15:0] MAGIC    = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        rom_cs,
  output logic        rom_clk,
  output logic        rom_mosi,
  input  logic        rom_miso,
  output logic [47:0] station_addr,
  output logic        image_ok,
  output logic        done,
  output logic        busy
);

  // The half period is never shorter than one microsecond of system clocks.
  localparam int HALF_EFF = (HALF_CYC > CLK_MHZ) ? HALF_CYC : CLK_MHZ;

  logic        sh_run, sh_tick;
  logic        sq_go, sq_wide;
  logic [7:0]  sq_addr;
  logic [15:0] sh_word;
  logic        sh_word_valid;

  eecfg_tick #(
    .HALF_CYC (HALF_EFF)
  ) u_tick (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .run_i  (sh_run),
    .tick_o (sh_tick)
  );

  eecfg_shifter u_shifter (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .go_i         (sq_go),
    .addr_i       (sq_addr),
    .wide_i       (sq_wide),
    .tick_i       (sh_tick),
    .sdi_i        (rom_miso),
    .run_o        (sh_run),
    .cs_o         (rom_cs),
    .sk_o         (rom_clk),
    .sdo_o        (rom_mosi),
    .word_o       (sh_word),
    .word_valid_o (sh_word_valid)
  );

  eecfg_seq #(
    .WORDS (WORDS),
    .MAGIC (MAGIC)
  ) u_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .word_valid_i (sh_word_valid),
    .word_i       (sh_word),
    .go_o         (sq_go),
    .addr_o       (sq_addr),
    .wide_o       (sq_wide),
    .station_o    (station_addr),
    .ok_o         (image_ok),
    .done_o       (done),
    .busy_o       (busy)
  );

  assert_select_only_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> busy);

endmodule

// File: tb/test_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module test_eeprom_cfg_loader;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rom_cs, rom_clk, rom_mosi;
  logic        rom_miso = 1'b1;
  logic [47:0] station_addr;
  logic        image_ok, done, busy;

  always #5 clk = ~clk;

  eeprom_cfg_loader #(.HALF_CYC(HALF), .CLK_MHZ(1)) i_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rom_cs(rom_cs), .rom_clk(rom_clk), .rom_mosi(rom_mosi), .rom_miso(rom_miso),
    .station_addr(station_addr), .image_ok(image_ok), .done(done), .busy(busy)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  int model_aw = 6;
  logic prev_sk = 1'b0, prev_cs = 1'b0, prev_di = 1'b0;
  logic [12:0] frame = '0;
  logic [15:0] outw = 16'hFFFF;
  int rc = 0, since = 0;
  int cs_rises = 0, frame_errs = 0, timing_errs = 0, di_errs = 0, sk_errs = 0;
  int nlog = 0;
  int log_addr [128];
  int log_bits [128];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (done) done_cnt++;
      if (rom_clk && !rom_cs) sk_errs++;
      if (rom_clk && prev_sk && rom_mosi != prev_di) di_errs++;
      if (rom_cs && !prev_cs) begin cs_rises++; rc = 0; end
      if (!rom_cs && prev_cs && rc != 29) frame_errs++;
      if (rom_clk != prev_sk) begin
        if (rom_clk) begin
          if (rc > 0 && since != HALF) timing_errs++;
          if (rc < 13) begin
            frame = {frame[11:0], rom_mosi};
            rc++;
            if (rc == 13) begin
              int p;
              p = -1;
              for (int b = 0; b < 13; b++) if (frame[b]) p = b;
              if (p < 2) begin
                frame_errs++;
                outw = 16'hFFFF;
              end else begin
                int ab, ad;
                if (frame[p-1] != 1'b1 || frame[p-2] != 1'b0) frame_errs++;
                ab = p - 2;
                ad = int'(frame) & ((1 << ab) - 1);
                if (nlog < 128) begin
                  log_addr[nlog] = ad;
                  log_bits[nlog] = ab;
                  nlog++;
                end
                outw = (ab == model_aw) ? mem[ad] : 16'hFFFF;
              end
            end
          end else if (rc < 29) begin
            rom_miso = outw[15 - (rc - 13)];
            rc++;
          end
        end else if (since != HALF) timing_errs++;
        since = 0;
      end
      prev_sk = rom_clk;
      prev_cs = rom_cs;
      prev_di = rom_mosi;
    end
  end

  // ---------------- stimulus table ----------------
  // {part address bits[21:18], seed[17:2], corrupt[1], word0 all-ones[0]}
  localparam int NCASE = 6;
  localparam logic [21:0] CASES [NCASE] = '{
    {4'd6, 16'h1234, 1'b0, 1'b0},
    {4'd8, 16'h5A5A, 1'b0, 1'b0},
    {4'd6, 16'h0F0F, 1'b1, 1'b0},
    {4'd8, 16'h7777, 1'b1, 1'b0},
    {4'd6, 16'h2468, 1'b0, 1'b1},
    {4'd8, 16'h1357, 1'b0, 1'b1}
  };

  int          exp_bits;
  logic        exp_ok;
  logic [47:0] exp_station;

  task automatic build_image(input int aw, input logic [15:0] seed,
                             input bit corrupt, input bit w0ones);
    logic [15:0] s;
    logic [15:0] rd [64];
    model_aw = aw;
    for (int i = 0; i < 256; i++) mem[i] = 16'((i + 3) * 16'h0101) ^ seed;
    s = 16'h0;
    for (int i = 0; i < 63; i++) begin
      mem[i] = 16'(seed * (i + 1)) ^ 16'(i * 257);
      if (i == 0 && w0ones) mem[i] = 16'hFFFF;
      s = s + mem[i];
    end
    mem[63] = 16'hBABA - s;
    if (corrupt) mem[63] = mem[63] ^ 16'h0001;
    exp_bits = (aw == 8) ? 8 : ((mem[0] == 16'hFFFF) ? 8 : 6);
    s = 16'h0;
    for (int i = 0; i < 64; i++) begin
      rd[i] = (exp_bits == aw) ? mem[i] : 16'hFFFF;
      s = s + rd[i];
    end
    exp_ok = (s == 16'hBABA);
    exp_station = exp_ok ? {rd[2], rd[1], rd[0]} : 48'h0;
  endtask

  task automatic clear_log();
    cs_rises = 0; frame_errs = 0; timing_errs = 0; di_errs = 0; sk_errs = 0;
    nlog = 0; done_cnt = 0;
  endtask

  task automatic wait_done();
    int w;
    w = 0;
    while (done_cnt == 0 && w < 40000) begin
      @(negedge clk);
      w++;
    end
    chk(done_cnt != 0, "R12", "run finished", 64'(done_cnt), 64'd1);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_run(input string tag);
    int order_bad;
    order_bad = 0;
    if (nlog != 65) order_bad++;
    else begin
      if (log_addr[0] != 0 || log_bits[0] != 6) order_bad++;
      for (int k = 0; k < 64; k++)
        if (log_addr[k+1] != k || log_bits[k+1] != exp_bits) order_bad++;
    end
    chk(frame_errs == 0, "R1", {tag, " frame format"}, 64'(frame_errs), 64'd0);
    chk(order_bad == 0, "R5", {tag, " probe and address width"}, 64'(order_bad), 64'd0);
    chk(cs_rises == 65, "R6", {tag, " accesses per run"}, 64'(cs_rises), 64'd65);
    chk(timing_errs == 0 && di_errs == 0, "R3", {tag, " clock timing and data hold"},
        64'(timing_errs + di_errs), 64'd0);
    chk(sk_errs == 0, "R4", {tag, " clock without select"}, 64'(sk_errs), 64'd0);
    chk(image_ok == exp_ok, "R7", {tag, " image_ok"}, 64'(image_ok), 64'(exp_ok));
    chk(station_addr == exp_station, exp_ok ? "R8" : "R9", {tag, " station_addr (R2 data)"},
        64'(station_addr), 64'(exp_station));
    chk(done_cnt == 1 && !busy, "R12", {tag, " one done pulse"}, 64'(done_cnt), 64'd1);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [47:0] held_sta;
    logic        held_ok;

    build_image(int'(CASES[0][21:18]), CASES[0][17:2], CASES[0][1], CASES[0][0]);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !image_ok, "R10", "reset flags", {61'd0, busy, done, image_ok}, 64'd0);
    chk(station_addr == 48'h0, "R10", "reset station", 64'(station_addr), 64'd0);
    chk(!rom_cs && !rom_clk && !rom_mosi, "R10", "reset pins",
        {61'd0, rom_cs, rom_clk, rom_mosi}, 64'd0);

    clear_log();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R10", "run starts after reset", 64'(busy), 64'd1);
    wait_done();
    check_run("boot R10");

    for (int c = 0; c < NCASE; c++) begin
      build_image(int'(CASES[c][21:18]), CASES[c][17:2], CASES[c][1], CASES[c][0]);
      clear_log();
      pulse_start();
      wait_done();
      check_run($sformatf("case%0d", c));
    end

    // R11: start pulses during a run are ignored
    build_image(6, 16'h4321, 1'b0, 1'b0);
    clear_log();
    pulse_start();
    repeat (500) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy mid-run", 64'(busy), 64'd1);
    pulse_start();
    repeat (1500) @(negedge clk);
    pulse_start();
    wait_done();
    chk(cs_rises == 65, "R11", "accesses with extra start", 64'(cs_rises), 64'd65);
    chk(done_cnt == 1, "R11", "done pulses with extra start", 64'(done_cnt), 64'd1);
    chk(image_ok == 1'b1, "R11", "result after extra start", 64'(image_ok), 64'd1);

    // R12: results held while idle
    held_sta = station_addr;
    held_ok  = image_ok;
    repeat (300) @(negedge clk);
    chk(station_addr == held_sta && image_ok == held_ok && !busy && cs_rises == 65,
        "R12", "results held while idle", 64'(station_addr), 64'(held_sta));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule